// File: doc/BRIEF.md
# Caption Pair Capture

This block takes the already-sliced serial bit stream of a closed-caption line and turns it into a held pair of bytes. Upstream logic supplies the current line number, a field flag, a start-bit detect pulse, and one sample strobe per data bit together with the sampled bit. When the line and field match the configured acquisition window, a start pulse opens a capture of sixteen bits. The bits arrive least significant bit first, and each eight-bit group is seven data bits followed by one odd-parity bit. Each byte is stored with its seven data bits in the low positions and a parity-error flag in the top bit.

The captured pair leaves the block on a valid/ready output. `pair_valid` rises when a pair completes. The consumer clears it by asserting `pair_ready` while it is high. There is no back-pressure: a new pair always overwrites the held one, even if the previous pair was never consumed. `data_ready_n` is the active-low image of `pair_valid`, for use as an interrupt. Status pins report the field the pair came from, whether the pair looks like extended-data-service traffic, and a parity shut-down condition that is raised by a run of corrupted pairs.

Three configuration pins shape the capture. A field select picks field 1 or field 2. A window width picks either the single caption line or a five-line band in both fields. An inhibit pin stops all capture.

Top module: `cc_pair_capture`

## Requirements
- R1: `byte_a` holds the first eight received bits and `byte_b` the next eight. In each byte, positions 0..6 hold the first seven bits received for that byte (data bits 1..7) and position 7 holds the parity-error flag.
- R2: Parity is odd over all eight received bits of a byte. The error flag in position 7 is 1 exactly when the count of ones among those eight bits is even.
- R3: With `cfg_wide_win`=0, capture happens only on line 21 and only when `field_in` equals `cfg_field_sel`. Field encoding is 0 = field 1 and 1 = field 2.
- R4: With `cfg_wide_win`=1, capture happens on lines 19 to 23 in either field, whatever the value of `cfg_field_sel`. Lines 18 and 24 are refused.
- R5: While `cfg_inhibit`=1, no capture starts, and `pair_valid`, `byte_a`, `byte_b` and status keep their values.
- R6: A start pulse inside the window, followed by sixteen strobes, sets `pair_valid`=1 and `data_ready_n`=0. The change becomes visible in the second cycle after the clock edge that samples the last bit. After reset, `pair_valid`=0, `data_ready_n`=1, and both bytes and all status pins are 0.
- R7: `pair_ready`=1 while `pair_valid`=1 clears `pair_valid` on the next edge. A completed pair overwrites the held pair and sets `pair_valid` whether or not the previous pair was consumed.
- R8: `st_field` gives the field of the line where capture started (0 = field 1). `st_eds`=1 exactly when that field is field 2 and the seven data bits of `byte_a` form a value from 0x01 to 0x0F.
- R9: `st_shutdown` rises when `PAR_LIMIT` (default 4) consecutive pairs each carry at least one parity error. A pair with no error clears it.
- R10: If the line leaves the window, or inhibit rises, before the sixteenth strobe, the partial pair is dropped. Outputs are unchanged, and the next start begins a fresh sixteen-bit capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_num | input | LINE_W | Current video line number |
| field_in | input | 1 | Current field, 0 = field 1, 1 = field 2 |
| start_det | input | 1 | Start-bit detected pulse |
| bit_strobe | input | 1 | One-cycle sample strobe for `bit_data` |
| bit_data | input | 1 | Sliced serial data bit |
| cfg_field_sel | input | 1 | Field to decode in the narrow window |
| cfg_wide_win | input | 1 | 0 = line 21 only, 1 = lines 19..23 of both fields |
| cfg_inhibit | input | 1 | 1 blocks all capture |
| pair_ready | input | 1 | Consumer accepts the held pair |
| pair_valid | output | 1 | A captured pair is held |
| byte_a | output | 8 | First byte, parity-error flag in bit 7 |
| byte_b | output | 8 | Second byte, parity-error flag in bit 7 |
| data_ready_n | output | 1 | Active-low data ready |
| st_field | output | 1 | Field of the held pair |
| st_eds | output | 1 | Held pair is extended-data-service traffic |
| st_shutdown | output | 1 | Parity shut-down condition |

## Verification
The parity shut-down flag is the hardest state to reach. It needs `PAR_LIMIT` complete pairs in a row, each with a corrupted byte and none clean. The stimulus sends four pairs whose first byte has an even count of ones, checks the flag after the third and after the fourth, and then sends a clean pair to clear it. The mid-line abort is reached by moving the line counter out of the window after eight strobes, then restarting on the right line. This shows that no stale bits leak into the next pair.

// File: rtl/cc_cap_pkg.sv
package cc_cap_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned PAIR_BITS = 2 * BYTE_W;

  // Data bits in the low positions; top bit is 1 when the count of ones is even.
  function automatic logic [BYTE_W-1:0] tag_byte(input logic [BYTE_W-1:0] raw);
    tag_byte = {~(^raw), raw[BYTE_W-2:0]};
  endfunction
endpackage

// File: rtl/cc_line_gate.sv
module cc_line_gate #(
  parameter int unsigned LINE_W   = 10,
  parameter int unsigned CAP_LINE = 21,
  parameter int unsigned WIN_SPAN = 2
) (
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_in,
  input  logic              field_sel,
  input  logic              wide_win,
  input  logic              inhibit,
  output logic              qual
);
  localparam logic [LINE_W-1:0] LINE_MID = LINE_W'(CAP_LINE);
  localparam logic [LINE_W-1:0] LINE_LO  = LINE_W'(CAP_LINE - WIN_SPAN);
  localparam logic [LINE_W-1:0] LINE_HI  = LINE_W'(CAP_LINE + WIN_SPAN);

  logic line_ok;
  logic field_ok;

  always_comb begin
    if (wide_win) begin
      line_ok  = (line_num >= LINE_LO) && (line_num <= LINE_HI);
      field_ok = 1'b1;
    end else begin
      line_ok  = (line_num == LINE_MID);
      field_ok = (field_in == field_sel);
    end
    qual = !inhibit && line_ok && field_ok;
  end
endmodule

// File: rtl/cc_bit_shifter.sv
module cc_bit_shifter
  import cc_cap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 qual,
  input  logic                 start,
  input  logic                 strobe,
  input  logic                 din,
  input  logic                 field_in,
  output logic                 done,
  output logic [PAIR_BITS-1:0] bits,
  output logic                 cap_field
);
  localparam int unsigned      CNT_W = $clog2(PAIR_BITS);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(PAIR_BITS - 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      bits      <= '0;
      done      <= 1'b0;
      cap_field <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start && qual) begin
          busy      <= 1'b1;
          cnt       <= '0;
          cap_field <= field_in;
        end
      end else if (!qual) begin
        busy <= 1'b0;                        // abort: partial pair dropped
      end else if (strobe) begin
        bits <= {din, bits[PAIR_BITS-1:1]};  // LSB first
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_GATE_BLOCKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> !busy); // R10

  AST_NO_DONE_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> !done); // R5
endmodule

// File: rtl/cc_pair_hold.sv
module cc_pair_hold
  import cc_cap_pkg::*;
#(
  parameter int unsigned PAR_LIMIT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done,
  input  logic [PAIR_BITS-1:0] bits,
  input  logic                 cap_field,
  input  logic                 pair_ready,
  output logic [BYTE_W-1:0]    byte_a,
  output logic [BYTE_W-1:0]    byte_b,
  output logic                 pair_valid,
  output logic                 st_field,
  output logic                 st_eds,
  output logic                 st_shutdown
);
  localparam int unsigned      ERR_W   = $clog2(PAR_LIMIT + 1);
  localparam logic [ERR_W-1:0] ERR_TOP = ERR_W'(PAR_LIMIT);
  localparam int unsigned      DATA_W  = BYTE_W - 1;

  logic [BYTE_W-1:0] tag_a, tag_b;
  logic              any_err;
  logic              eds_hit;
  logic [ERR_W-1:0]  err_run;

  always_comb begin
    tag_a   = tag_byte(bits[BYTE_W-1:0]);
    tag_b   = tag_byte(bits[PAIR_BITS-1:BYTE_W]);
    any_err = tag_a[BYTE_W-1] | tag_b[BYTE_W-1];
    eds_hit = cap_field && (tag_a[DATA_W-1:0] != '0) &&
              (tag_a[DATA_W-1:0] <= DATA_W'(15));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_a     <= '0;
      byte_b     <= '0;
      pair_valid <= 1'b0;
      st_field   <= 1'b0;
      st_eds     <= 1'b0;
      err_run    <= '0;
    end else if (done) begin
      byte_a     <= tag_a;
      byte_b     <= tag_b;
      pair_valid <= 1'b1;                  // overwrite, no back-pressure
      st_field   <= cap_field;
      st_eds     <= eds_hit;
      if (!any_err)              err_run <= '0;
      else if (err_run != ERR_TOP) err_run <= err_run + 1'b1;
    end else if (pair_ready) begin
      pair_valid <= 1'b0;
    end
  end

  assign st_shutdown = (err_run == ERR_TOP);

  AST_DONE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> pair_valid); // R6

  AST_READY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && pair_ready && !done) |=> !pair_valid); // R7

  AST_HOLD_WITHOUT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(byte_a) && $stable(byte_b) && $stable(st_field))); // R5

  AST_CLEAN_PAIR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ($countones(bits[7:0]) % 2 == 1) && ($countones(bits[15:8]) % 2 == 1))
      |=> !st_shutdown); // R9
endmodule

// File: rtl/cc_pair_capture.sv
module cc_pair_capture
  import cc_cap_pkg::*;
#(
  parameter int unsigned LINE_W    = 10,
  parameter int unsigned CAP_LINE  = 21,
  parameter int unsigned WIN_SPAN  = 2,
  parameter int unsigned PAR_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_in,
  input  logic              start_det,
  input  logic              bit_strobe,
  input  logic              bit_data,
  input  logic              cfg_field_sel,
  input  logic              cfg_wide_win,
  input  logic              cfg_inhibit,
  input  logic              pair_ready,
  output logic              pair_valid,
  output logic [7:0]        byte_a,
  output logic [7:0]        byte_b,
  output logic              data_ready_n,
  output logic              st_field,
  output logic              st_eds,
  output logic              st_shutdown
);
  logic                 qual;
  logic                 done;
  logic [PAIR_BITS-1:0] bits;
  logic                 cap_field;

  cc_line_gate #(
    .LINE_W(LINE_W), .CAP_LINE(CAP_LINE), .WIN_SPAN(WIN_SPAN)
  ) i_gate (
    .line_num(line_num), .field_in(field_in), .field_sel(cfg_field_sel),
    .wide_win(cfg_wide_win), .inhibit(cfg_inhibit), .qual(qual)
  );

  cc_bit_shifter i_shift (
    .clk(clk), .rst_n(rst_n), .qual(qual), .start(start_det),
    .strobe(bit_strobe), .din(bit_data), .field_in(field_in),
    .done(done), .bits(bits), .cap_field(cap_field)
  );

  cc_pair_hold #(.PAR_LIMIT(PAR_LIMIT)) i_hold (
    .clk(clk), .rst_n(rst_n), .done(done), .bits(bits),
    .cap_field(cap_field), .pair_ready(pair_ready),
    .byte_a(byte_a), .byte_b(byte_b), .pair_valid(pair_valid),
    .st_field(st_field), .st_eds(st_eds), .st_shutdown(st_shutdown)
  );

  assign data_ready_n = ~pair_valid;

  AST_DR_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pair_valid) |-> !data_ready_n); // R6
endmodule

// File: tb/test_cc_pair_capture.sv
module test_cc_pair_capture;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] line_num = '0;
  logic       field_in = 1'b0, start_det = 1'b0, bit_strobe = 1'b0, bit_data = 1'b0;
  logic       cfg_field_sel = 1'b0, cfg_wide_win = 1'b0, cfg_inhibit = 1'b0, pair_ready = 1'b0;
  logic       pair_valid, data_ready_n, st_field, st_eds, st_shutdown;
  logic [7:0] byte_a, byte_b;

  always #4 clk = ~clk; // 125 MHz

  cc_pair_capture i_cc_pair_capture (
    .clk(clk), .rst_n(rst_n), .line_num(line_num), .field_in(field_in),
    .start_det(start_det), .bit_strobe(bit_strobe), .bit_data(bit_data),
    .cfg_field_sel(cfg_field_sel), .cfg_wide_win(cfg_wide_win),
    .cfg_inhibit(cfg_inhibit), .pair_ready(pair_ready), .pair_valid(pair_valid),
    .byte_a(byte_a), .byte_b(byte_b), .data_ready_n(data_ready_n),
    .st_field(st_field), .st_eds(st_eds), .st_shutdown(st_shutdown)
  );

  typedef struct packed {
    logic [9:0] line;
    logic       fld;
    logic       wide;
    logic       fsel;
    logic       inh;
    logic       cap;
    logic [7:0] ba;
    logic [7:0] bb;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{10'd21, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h94, 8'h2C}, // R3 field 1 narrow
    '{10'd21, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h55, 8'h55}, // R3 wrong field
    '{10'd21, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h01, 8'h03}, // R3 field 2, R8 eds
    '{10'd20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h15, 8'h15}, // R3 wrong line
    '{10'd19, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hC1, 8'h80}, // R4 low edge
    '{10'd23, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'hFF}, // R4 high edge, R2
    '{10'd24, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0E, 8'h0E}, // R4 above band
    '{10'd18, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0E, 8'h0E}, // R4 below band
    '{10'd21, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h94, 8'h2C}, // R5 inhibit
    '{10'd22, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'hE5, 8'h7F}  // R4 inside band
  };

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_a = '0, exp_b = '0;
  logic exp_fld = 1'b0, exp_eds = 1'b0, exp_valid = 1'b0;
  int sd_run = 0;
  logic valid_at_gap;

  function automatic logic perr(input logic [7:0] b);
    return ($countones(b) % 2) == 0;
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Bench model of a completed pair.
  task automatic model_pair(input logic [7:0] ba, input logic [7:0] bb, input logic fld);
    exp_a     = {perr(ba), ba[6:0]};
    exp_b     = {perr(bb), bb[6:0]};
    exp_fld   = fld;
    exp_eds   = fld && (ba[6:0] >= 7'd1) && (ba[6:0] <= 7'd15);
    exp_valid = 1'b1;
    if (perr(ba) || perr(bb)) sd_run = (sd_run < 4) ? sd_run + 1 : 4;
    else sd_run = 0;
  endtask

  task automatic pulse_start();
    start_det = 1'b1;
    @(negedge clk);
    start_det = 1'b0;
  endtask

  task automatic send_bits(input logic [15:0] word, input int nbits);
    for (int k = 0; k < nbits; k++) begin
      bit_data   = word[k];
      bit_strobe = 1'b1;
      @(negedge clk);
      bit_strobe = 1'b0;
      valid_at_gap = pair_valid;
      @(negedge clk);
    end
  endtask

  task automatic send_pair(input logic [7:0] ba, input logic [7:0] bb);
    pulse_start();
    send_bits({bb, ba}, 16);
  endtask

  task automatic consume();
    pair_ready = 1'b1;
    @(negedge clk);
    pair_ready = 1'b0;
    exp_valid = 1'b0;
  endtask

  task automatic check_all(input string req);
    chk({req, " valid"}, pair_valid, exp_valid);
    chk({req, " dr_n"}, data_ready_n, !exp_valid);
    chk({req, " byte_a"}, byte_a, exp_a);
    chk({req, " byte_b"}, byte_b, exp_b);
    chk({req, " field"}, st_field, exp_fld);
    chk({req, " eds"}, st_eds, exp_eds);
    chk({req, " shutdown"}, st_shutdown, sd_run >= 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R6 reset");

    // Table walk: R1 R2 R3 R4 R5 R8
    for (int i = 0; i < 10; i++) begin
      vec_t v;
      v = VECS[i];
      consume();
      line_num = v.line; field_in = v.fld; cfg_wide_win = v.wide;
      cfg_field_sel = v.fsel; cfg_inhibit = v.inh;
      send_pair(v.ba, v.bb);
      if (v.cap) model_pair(v.ba, v.bb, v.fld);
      check_all($sformatf("R1 R3 R4 vec%0d", i));
    end
    cfg_inhibit = 1'b0;

    // R6: timing of data ready after the last sampled bit.
    consume();
    line_num = 10'd21; field_in = 1'b0; cfg_wide_win = 1'b0; cfg_field_sel = 1'b0;
    send_pair(8'h31, 8'h62);
    model_pair(8'h31, 8'h62, 1'b0);
    chk("R6 not yet valid one cycle after last bit", valid_at_gap, 0);
    check_all("R6 pair");

    // R7: overwrite without consume, then consume clears.
    send_pair(8'h4A, 8'h8F);
    model_pair(8'h4A, 8'h8F, 1'b0);
    check_all("R7 overwrite");
    consume();
    check_all("R7 ready clears");

    // R10: abort mid-pair, then fresh capture.
    pulse_start();
    send_bits(16'hFFFF, 8);
    line_num = 10'd22;
    @(negedge clk);
    line_num = 10'd21;
    @(negedge clk);
    check_all("R10 abort leaves outputs");
    send_pair(8'h13, 8'h25);
    model_pair(8'h13, 8'h25, 1'b0);
    check_all("R10 fresh capture");
    pulse_start();
    send_bits(16'h00FF, 5);
    cfg_inhibit = 1'b1;
    @(negedge clk);
    cfg_inhibit = 1'b0;
    send_pair(8'h07, 8'h0B);
    model_pair(8'h07, 8'h0B, 1'b0);
    check_all("R10 inhibit abort then fresh");

    // R9: parity shut-down run.
    for (int j = 0; j < 4; j++) begin
      send_pair(8'h00, 8'h01);
      model_pair(8'h00, 8'h01, 1'b0);
      check_all($sformatf("R9 bad pair %0d", j));
    end
    send_pair(8'h01, 8'h02);
    model_pair(8'h01, 8'h02, 1'b0);
    check_all("R9 clean pair clears");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule